// File: doc/BRIEF.md
# Successor-Index Next-Block Predictor

This block predicts which instruction-cache block fetch should visit next. Instead of a separate branch target buffer, every cache block carries its own prediction entry beside it: a valid bit, a flag saying the block holds a branch, a one-bit taken/not-taken state and a successor pointer naming the target block. Each cycle the fetch unit presents the block it is fetching and receives the predicted next block index, a flag telling whether that prediction follows a taken branch, and a reload request when the block's entry is not valid and must be predecoded again.

Predecode installs an entry when a block is filled; a branch starts out predicted not taken. When execution resolves a branch and the prediction was wrong, the entry is reversed at once: a taken outcome writes the real target into the successor pointer, a not-taken outcome returns the block to sequential fetch. There is no counter or hysteresis. A cache flush drops every entry together with the blocks, and a "confused" strobe from the byte queue invalidates a single incoherent block so that it is fetched and predecoded afresh. Only one taken branch can be predicted per block.

Top module: `succ_predictor`

## Requirements
- R1: After reset every entry is invalid: any lookup raises reloadReq, drives predTaken low and predicts sequential fetch.
- R2: When the looked-up entry is invalid, holds no branch, or is predicted not taken, predIdx is fetchIdx + 1 modulo 2^IDX_W (the last block wraps to 0) and predTaken is 0.
- R3: A fill with fillHasBranch = 1 makes the entry valid with its branch predicted not taken; from the next cycle a lookup of it gives reloadReq = 0, predTaken = 0 and a sequential predIdx.
- R4: A resolution with resTaken = 1 on a valid branch entry predicted not taken makes later lookups of that block return predTaken = 1 and predIdx = resTarget.
- R5: A resolution with resTaken = 0 on an entry predicted taken returns it to sequential fetch after that single wrong outcome, and a single later taken resolution makes it taken again.
- R6: A taken resolution whose target differs from the stored successor replaces the successor with resTarget.
- R7: A resolution or fill and a lookup of the same entry in one cycle return the old prediction; the write is seen from the next cycle.
- R8: confusedValid invalidates entry confusedIdx from the next cycle, so its lookup raises reloadReq; when a resolution names the same entry in the same cycle, the invalidation wins.
- R9: flush invalidates every entry from the next cycle and takes priority over a fill, resolution or confused strobe in the same cycle.
- R10: A resolution naming an invalid entry or an entry without a branch leaves the prediction unchanged.
- R11: A fill and a resolution of the same entry in the same cycle leave the freshly filled state (branch predicted not taken); a fill and a confused strobe of the same entry leave it invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchIdx | input | IDX_W | Block being fetched this cycle |
| fillValid | input | 1 | Predecode installs an entry |
| fillIdx | input | IDX_W | Block being installed |
| fillHasBranch | input | 1 | Installed block holds a branch |
| resValid | input | 1 | A branch outcome is reported |
| resIdx | input | IDX_W | Block holding the resolved branch |
| resTaken | input | 1 | Actual outcome was taken |
| resTarget | input | IDX_W | Block the taken branch went to |
| flush | input | 1 | Discard all entries |
| confusedValid | input | 1 | Block found incoherent |
| confusedIdx | input | IDX_W | Incoherent block |
| predIdx | output | IDX_W | Predicted next block |
| predTaken | output | 1 | Prediction follows a taken branch |
| reloadReq | output | 1 | Fetched block must be predecoded again |

## Verification
The bench builds the predictor with IDX_W = 4, a 16-block table, so that fetch of the last block and its wrap to block 0 is reached directly and randomly chosen fill, resolution and confused indices collide often enough to exercise every same-cycle priority case. A directed phase walks one branch through install, flip to taken, retarget, flip back and invalidation, then a long random phase with dense strobes is compared against a behavioural table model every cycle.

// File: rtl/succ_pred_pkg.sv
package succ_pred_pkg;

  // Write strobes issued by the control to the storage datapath.
  typedef struct packed {
    logic flushAll;   // clear every valid bit
    logic invEn;      // clear one valid bit
    logic fillEn;     // install one entry
    logic resEn;      // rewrite the direction / successor of one entry
    logic resTaken;   // direction written by resEn
  } strobe_t;

endpackage

// File: rtl/succ_pred_dp.sv
module succ_pred_dp
  import succ_pred_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [IDX_W-1:0] fetchIdx,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic             fillHasBranch,
  input  logic [IDX_W-1:0] invIdx,
  input  logic [IDX_W-1:0] resIdx,
  input  logic [IDX_W-1:0] resTarget,
  output logic             fValid,
  output logic             fBranch,
  output logic             fTaken,
  output logic [IDX_W-1:0] fSucc,
  output logic             rValid,
  output logic             rBranch,
  output logic             rTaken,
  output logic [IDX_W-1:0] rSucc
);

  localparam int NumBlocks = 1 << IDX_W;

  logic [NumBlocks-1:0] validQ;
  logic [NumBlocks-1:0] branchQ;
  logic [NumBlocks-1:0] takenQ;
  logic [IDX_W-1:0]     succQ [NumBlocks];

  // Valid bits: the only reset state; invalidation is written last so it wins.
  always_ff @(posedge clk) begin
    if (!rstN || strb.flushAll) begin
      validQ <= '0;
    end else begin
      if (strb.fillEn) validQ[fillIdx] <= 1'b1;
      if (strb.invEn)  validQ[invIdx]  <= 1'b0;
    end
  end

  // Payload: meaningful only while the valid bit is set, so no reset.
  always_ff @(posedge clk) begin
    if (strb.resEn) begin
      takenQ[resIdx] <= strb.resTaken;
      if (strb.resTaken) succQ[resIdx] <= resTarget;
    end
    if (strb.fillEn) begin
      branchQ[fillIdx] <= fillHasBranch;
      takenQ[fillIdx]  <= 1'b0;
    end
  end

  // Two read ports: fetch lookup and resolution compare.
  always_comb begin
    fValid  = validQ[fetchIdx];
    fBranch = branchQ[fetchIdx];
    fTaken  = takenQ[fetchIdx];
    fSucc   = succQ[fetchIdx];
    rValid  = validQ[resIdx];
    rBranch = branchQ[resIdx];
    rTaken  = takenQ[resIdx];
    rSucc   = succQ[resIdx];
  end

endmodule

// File: rtl/succ_pred_ctrl.sv
module succ_pred_ctrl
  import succ_pred_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] fetchIdx,
  input  logic             fillValid,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic             resValid,
  input  logic [IDX_W-1:0] resIdx,
  input  logic             resTaken,
  input  logic [IDX_W-1:0] resTarget,
  input  logic             flush,
  input  logic             confusedValid,
  input  logic [IDX_W-1:0] confusedIdx,
  input  logic             fValid,
  input  logic             fBranch,
  input  logic             fTaken,
  input  logic [IDX_W-1:0] fSucc,
  input  logic             rValid,
  input  logic             rBranch,
  input  logic             rTaken,
  input  logic [IDX_W-1:0] rSucc,
  output strobe_t          strb,
  output logic [IDX_W-1:0] predIdx,
  output logic             predTaken,
  output logic             reloadReq
);

  logic resHit;
  logic mispredict;
  logic invSame;
  logic fillSame;
  logic useSucc;
  logic [IDX_W-1:0] seqIdx;

  always_comb begin
    resHit     = rValid && rBranch;
    mispredict = (resTaken != rTaken) || (resTaken && (rSucc != resTarget));
    invSame    = confusedValid && (confusedIdx == resIdx);
    fillSame   = fillValid && (fillIdx == resIdx);

    strb.flushAll = flush;
    strb.invEn    = confusedValid && !flush;
    strb.fillEn   = fillValid && !flush;
    strb.resEn    = resValid && resHit && mispredict && !flush && !invSame && !fillSame;
    strb.resTaken = resTaken;
  end

  always_comb begin
    seqIdx    = fetchIdx + IDX_W'(1);
    useSucc   = fValid && fBranch && fTaken;
    predIdx   = useSucc ? fSucc : seqIdx;
    predTaken = useSucc;
    reloadReq = !fValid;
  end

endmodule

// File: rtl/succ_predictor.sv
module succ_predictor
  import succ_pred_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] fetchIdx,
  input  logic             fillValid,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic             fillHasBranch,
  input  logic             resValid,
  input  logic [IDX_W-1:0] resIdx,
  input  logic             resTaken,
  input  logic [IDX_W-1:0] resTarget,
  input  logic             flush,
  input  logic             confusedValid,
  input  logic [IDX_W-1:0] confusedIdx,
  output logic [IDX_W-1:0] predIdx,
  output logic             predTaken,
  output logic             reloadReq
);

  strobe_t          strb;
  logic             fValid, fBranch, fTaken;
  logic             rValid, rBranch, rTaken;
  logic [IDX_W-1:0] fSucc, rSucc;

  succ_pred_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .fetchIdx(fetchIdx), .fillValid(fillValid), .fillIdx(fillIdx),
    .resValid(resValid), .resIdx(resIdx), .resTaken(resTaken), .resTarget(resTarget),
    .flush(flush), .confusedValid(confusedValid), .confusedIdx(confusedIdx),
    .fValid(fValid), .fBranch(fBranch), .fTaken(fTaken), .fSucc(fSucc),
    .rValid(rValid), .rBranch(rBranch), .rTaken(rTaken), .rSucc(rSucc),
    .strb(strb), .predIdx(predIdx), .predTaken(predTaken), .reloadReq(reloadReq)
  );

  succ_pred_dp #(.IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fetchIdx(fetchIdx),
    .fillIdx(fillIdx), .fillHasBranch(fillHasBranch), .invIdx(confusedIdx),
    .resIdx(resIdx), .resTarget(resTarget),
    .fValid(fValid), .fBranch(fBranch), .fTaken(fTaken), .fSucc(fSucc),
    .rValid(rValid), .rBranch(rBranch), .rTaken(rTaken), .rSucc(rSucc)
  );

endmodule

// File: rtl/succ_predictor_chk.sv
module succ_predictor_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic [IDX_W-1:0] fetchIdx,
  input logic             fillValid,
  input logic [IDX_W-1:0] fillIdx,
  input logic             fillHasBranch,
  input logic             resValid,
  input logic [IDX_W-1:0] resIdx,
  input logic             resTaken,
  input logic [IDX_W-1:0] resTarget,
  input logic             flush,
  input logic             confusedValid,
  input logic [IDX_W-1:0] confusedIdx,
  input logic [IDX_W-1:0] predIdx,
  input logic             predTaken,
  input logic             reloadReq
);

  // R2
  seq_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    !predTaken |-> predIdx == IDX_W'(fetchIdx + IDX_W'(1)));

  // R1
  reload_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    reloadReq |-> !predTaken);

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> reloadReq);

  // R8
  confused_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(confusedValid) && fetchIdx == $past(confusedIdx)) |-> reloadReq);

  // R3
  fill_install_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(fillValid && !flush && !(confusedValid && confusedIdx == fillIdx))
     && fetchIdx == $past(fillIdx)) |-> (!reloadReq && !predTaken));

endmodule

bind succ_predictor succ_predictor_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/succ_predictor_tb.sv
`timescale 1ns/1ps
module succ_predictor_tb;

  localparam int IW = 4;
  localparam int NB = 1 << IW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [IW-1:0] fetchIdx = '0, fillIdx = '0, resIdx = '0, resTarget = '0, confusedIdx = '0;
  logic fillValid = 1'b0, fillHasBranch = 1'b0, resValid = 1'b0, resTaken = 1'b0;
  logic flush = 1'b0, confusedValid = 1'b0;
  logic [IW-1:0] predIdx;
  logic predTaken, reloadReq;

  int tests = 0;
  int fails = 0;

  // behavioural table model
  bit mV [NB];
  bit mB [NB];
  bit mT [NB];
  int mS [NB];

  always #10 clk = ~clk;

  succ_predictor #(.IDX_W(IW)) u_dut (.*);

  task automatic idle();
    fillValid = 0; resValid = 0; flush = 0; confusedValid = 0;
  endtask

  task automatic checkOut(string tag);
    int eIdx;
    bit eTk, eRl;
    int f = fetchIdx;
    eRl = !mV[f];
    eTk = mV[f] && mB[f] && mT[f];
    eIdx = eTk ? mS[f] : (f + 1) % NB;
    tests++;
    if (predIdx !== IW'(eIdx) || predTaken !== eTk || reloadReq !== eRl) begin
      fails++;
      $display("FAIL %s: fetch=%0d got idx=%0d tk=%0b rl=%0b expected idx=%0d tk=%0b rl=%0b",
               tag, f, predIdx, predTaken, reloadReq, eIdx, eTk, eRl);
    end
  endtask

  task automatic modelUpdate();
    bit resApply;
    if (!rstN || flush) begin
      for (int i = 0; i < NB; i++) mV[i] = 0;
      return;
    end
    resApply = resValid && mV[resIdx] && mB[resIdx]
               && !(confusedValid && confusedIdx == resIdx)
               && !(fillValid && fillIdx == resIdx);
    if (resApply) begin
      mT[resIdx] = resTaken;
      if (resTaken) mS[resIdx] = resTarget;
    end
    if (fillValid) begin
      mV[fillIdx] = 1; mB[fillIdx] = fillHasBranch; mT[fillIdx] = 0;
    end
    if (confusedValid) mV[confusedIdx] = 0;
  endtask

  // inputs already driven; check, clock, update model, return at negedge
  task automatic step(string tag);
    #1 checkOut(tag);
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    idle();
  endtask

  task automatic look(int f, string tag);
    fetchIdx = IW'(f);
    #1 checkOut(tag);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin mV[i] = 0; mB[i] = 0; mT[i] = 0; mS[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state, R2 wrap at last block
    look(0, "R1 reset lookup");
    look(NB - 1, "R2 wrap last block");
    // R3 install
    fillValid = 1; fillIdx = 3; fillHasBranch = 1; fetchIdx = 3;
    step("R7 fill same-cycle lookup old");
    look(3, "R3 installed not taken");
    // R4 flip to taken, R7 same-cycle old value
    resValid = 1; resIdx = 3; resTaken = 1; resTarget = 9; fetchIdx = 3;
    step("R7 resolve same-cycle lookup old");
    look(3, "R4 flipped taken");
    // R6 retarget
    resValid = 1; resIdx = 3; resTaken = 1; resTarget = 12;
    step("R6 before retarget");
    look(3, "R6 retargeted");
    // R5 single wrong outcome flips back, then forward again
    resValid = 1; resIdx = 3; resTaken = 0;
    step("R5 before flip back");
    look(3, "R5 back to sequential");
    resValid = 1; resIdx = 3; resTaken = 1; resTarget = 9;
    step("R5 before flip again");
    look(3, "R5 taken again");
    // R10 resolution on invalid and branchless entries
    resValid = 1; resIdx = 5; resTaken = 1; resTarget = 1; fetchIdx = 5;
    step("R10 before invalid resolve");
    look(5, "R10 invalid entry unchanged");
    fillValid = 1; fillIdx = 6; fillHasBranch = 0;
    step("R10 fill branchless");
    resValid = 1; resIdx = 6; resTaken = 1; resTarget = 2;
    step("R10 before branchless resolve");
    look(6, "R10 branchless unchanged");
    // R8 confused wins over resolution
    resValid = 1; resIdx = 3; resTaken = 0; confusedValid = 1; confusedIdx = 3;
    step("R8 before confused");
    look(3, "R8 confused invalidated");
    // R11 fill beats resolution; fill with confused leaves invalid
    fillValid = 1; fillIdx = 7; fillHasBranch = 1;
    step("R11 first fill");
    fillValid = 1; fillIdx = 7; fillHasBranch = 1; resValid = 1; resIdx = 7; resTaken = 1; resTarget = 2;
    step("R11 fill with resolve");
    look(7, "R11 fill wins");
    fillValid = 1; fillIdx = 8; fillHasBranch = 1; confusedValid = 1; confusedIdx = 8;
    step("R11 fill with confused");
    look(8, "R11 confused beats fill");
    // R9 flush beats fill
    flush = 1; fillValid = 1; fillIdx = 10; fillHasBranch = 1;
    step("R9 before flush");
    look(10, "R9 flush beats fill");
    look(7, "R9 flush clears all");
    // random phase, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      fetchIdx      = IW'($urandom);
      fillValid     = ($urandom % 4) == 0;
      fillIdx       = IW'($urandom);
      fillHasBranch = ($urandom % 4) != 0;
      resValid      = ($urandom % 2) == 0;
      resIdx        = IW'($urandom);
      resTaken      = ($urandom % 2) == 0;
      resTarget     = IW'($urandom);
      flush         = ($urandom % 97) == 0;
      confusedValid = ($urandom % 13) == 0;
      confusedIdx   = IW'($urandom);
      step("R2 R4 R5 R6 random");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++; tests++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule